// File: doc/BRIEF.md
# Paged Special-Register Address Decoder

This block sits beside an 8051-style core and decodes its direct-address accesses that fall in the upper half of the direct space (0x80 to 0xFF). A page-select register chooses which bank of special registers answers at a given address. The same direct address can therefore reach different storage depending on the active page. The page-select register itself answers at the same address whatever page is active, so software can always change the page.

Accesses come in two kinds. A byte access reads or writes a whole register. A bit access names one bit of one register. Only registers whose address ends in 0x0 or 0x8 can be reached by bit access. The block holds a small set of example registers spread over two populated pages. It drives one-hot select and write-enable lines for them and returns read data combinationally. Writes to addresses that no register occupies leave all state unchanged.

Top module: `sfr_page_decoder`

## Requirements
- R1: Accesses whose direct address (byte) or bit address (bit access) is below 0x80 are ignored. They assert no select or write-enable, return rd_data 0x00, and change no register.
- R2: The page-select register answers byte accesses at 0xBF on every page, including unpopulated ones. It resets to 0x00, and a byte read returns the page in use.
- R3: A byte write to 0xBF loads the page from the next cycle on. A read issued in the same cycle as that write sees the old page.
- R4: The register at 0x80 (select index 0) is one storage element, reachable on page 0x00 and on page 0x0F.
- R5: At 0x88, page 0x00 reaches index 1 and page 0x0F reaches index 2, which is separate storage. Index 3 at 0x9A exists on page 0x00 only. Index 4 at 0xC3 exists on page 0x0F only.
- R6: An access to an address that no register occupies on the active page is reserved. A write there modifies nothing, and a read there returns 0x00 with no select asserted.
- R7: On a page other than 0x00 or 0x0F, every address except 0xBF is unoccupied.
- R8: With bit_mode high, bit address b (b >= 0x80) targets the register at {b[7:3],3'b000}, bit b[2:0]. A bit write changes only that bit to bit_val. A bit read returns the bit on rd_data[0] with rd_data[7:1] = 0.
- R9: Bit accesses never reach a register whose address does not end in 0x0 or 0x8. For example, bit addresses 0xB8 to 0xBF target the unoccupied 0xB8 and leave the page unchanged.
- R10: A byte write replaces the whole register on the rising edge while wr_en is high. reg_sel[i] is high while a read or write hits index i, and reg_we[i] is high only while a write hits it.
- R11: While rd_en is low, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 8 | Direct address, or bit address when bit_mode is high |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Byte write data |
| bit_mode | input | 1 | High for a single-bit access |
| bit_val | input | 1 | Value written by a bit write |
| rd_data | output | DATA_W | Combinational read data |
| reg_sel | output | NUM_REG | One-hot register select (index order as in R4, R5) |
| reg_we | output | NUM_REG | One-hot register write enable |

## Verification
rd_data, reg_sel and reg_we are combinational, so they are due in the same cycle as the access. The bench drives each access on a falling edge and compares these outputs a quarter period later, before the next rising edge. The effect of a write, whether to a data register or to the page, first shows in the cycle after the write. Every write is therefore confirmed by a read issued in a later cycle, and the R3 case deliberately reads in the write cycle to see the old page. A scoreboard queue holds the expected values for each access in issue order and is drained by the monitor.

// File: rtl/sfr_dec_pkg.sv
package sfr_dec_pkg;

   localparam int unsigned ADDR_W    = 8;
   localparam int unsigned PAGE_W    = 8;
   localparam int unsigned MAP_REGS  = 5;

   localparam logic [ADDR_W-1:0] PAGE_SEL_ADDR = 8'hBF;
   localparam logic [PAGE_W-1:0] PAGE_LO       = 8'h00;
   localparam logic [PAGE_W-1:0] PAGE_HI       = 8'h0F;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [PAGE_W-1:0] page;
      logic              shared;
   } reg_desc_t;

   // Example register map; index is the select/write-enable bit position.
   function automatic reg_desc_t reg_desc(input int unsigned idx);
      reg_desc_t d;
      case (idx)
         0:       d = '{addr: 8'h80, page: PAGE_LO, shared: 1'b1};
         1:       d = '{addr: 8'h88, page: PAGE_LO, shared: 1'b0};
         2:       d = '{addr: 8'h88, page: PAGE_HI, shared: 1'b0};
         3:       d = '{addr: 8'h9A, page: PAGE_LO, shared: 1'b0};
         4:       d = '{addr: 8'hC3, page: PAGE_HI, shared: 1'b0};
         default: d = '{addr: 8'h00, page: PAGE_LO, shared: 1'b0};
      endcase
      return d;
   endfunction

   function automatic logic page_populated(input logic [PAGE_W-1:0] pg);
      return (pg == PAGE_LO) || (pg == PAGE_HI);
   endfunction

endpackage

// File: rtl/sfr_page_reg.sv
module sfr_page_reg #(
   parameter int unsigned          PAGE_W     = 8,
   parameter logic [PAGE_W-1:0]    RESET_PAGE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PAGE_W-1:0] din,
   output logic [PAGE_W-1:0] page_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    page_q <= RESET_PAGE;
      else if (load) page_q <= din;
   end

endmodule

// File: rtl/sfr_addr_match.sv
module sfr_addr_match
   import sfr_dec_pkg::*;
#(
   parameter int unsigned NUM_REG = MAP_REGS
) (
   input  logic [ADDR_W-1:0]  eff_addr,
   input  logic [PAGE_W-1:0]  page,
   input  logic               in_space,
   output logic [NUM_REG-1:0] hit
);

   logic populated;
   assign populated = page_populated(page);

   for (genvar i = 0; i < NUM_REG; i++) begin : g_match
      localparam reg_desc_t DESC = reg_desc(i);
      if (DESC.shared) begin : g_shared
         assign hit[i] = in_space && populated && (eff_addr == DESC.addr);
      end else begin : g_paged
         assign hit[i] = in_space && (page == DESC.page) && (eff_addr == DESC.addr);
      end
   end

endmodule

// File: rtl/sfr_reg_bank.sv
module sfr_reg_bank #(
   parameter int unsigned NUM_REG = 5,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REG-1:0] hit,
   input  logic [NUM_REG-1:0] we,
   input  logic               bit_mode,
   input  logic [IDX_W-1:0]   bit_idx,
   input  logic               bit_val,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_byte
);

   logic [DATA_W-1:0] q     [NUM_REG];
   logic [DATA_W-1:0] masked[NUM_REG];

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      logic [DATA_W-1:0] next_val;
      always_comb begin
         next_val = q[i];
         if (bit_mode) next_val[bit_idx] = bit_val;
         else          next_val          = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= '0;
         else if (we[i]) q[i] <= next_val;
      end
      assign masked[i] = hit[i] ? q[i] : '0;
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NUM_REG; i++) rd_byte = rd_byte | masked[i];
   end

endmodule

// File: rtl/sfr_page_decoder.sv
module sfr_page_decoder
   import sfr_dec_pkg::*;
#(
   parameter int unsigned       NUM_REG    = MAP_REGS,
   parameter int unsigned       DATA_W     = 8,
   parameter logic [PAGE_W-1:0] RESET_PAGE = PAGE_LO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  dir_addr,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               bit_mode,
   input  logic               bit_val,
   output logic [DATA_W-1:0]  rd_data,
   output logic [NUM_REG-1:0] reg_sel,
   output logic [NUM_REG-1:0] reg_we
);

   localparam int unsigned IDX_W = $clog2(DATA_W);

   if (DATA_W != 8) begin : g_bad_width
      $error("sfr_page_decoder: DATA_W must be 8");
   end
   if (NUM_REG != MAP_REGS) begin : g_bad_count
      $error("sfr_page_decoder: NUM_REG must match the register map");
   end

   logic [PAGE_W-1:0] page_q;
   logic [ADDR_W-1:0] eff_addr;
   logic              in_space;
   logic              page_hit;
   logic [NUM_REG-1:0] hit;
   logic [DATA_W-1:0]  bank_rd;
   logic [IDX_W-1:0]   bit_idx;

   assign in_space = dir_addr[ADDR_W-1];
   assign eff_addr = bit_mode ? {dir_addr[ADDR_W-1:3], 3'b000} : dir_addr;
   assign bit_idx  = dir_addr[IDX_W-1:0];
   assign page_hit = in_space && !bit_mode && (dir_addr == PAGE_SEL_ADDR);

   sfr_page_reg #(.PAGE_W(PAGE_W), .RESET_PAGE(RESET_PAGE)) u_page (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wr_en && page_hit),
      .din    (wr_data[PAGE_W-1:0]),
      .page_q (page_q)
   );

   sfr_addr_match #(.NUM_REG(NUM_REG)) u_match (
      .eff_addr (eff_addr),
      .page     (page_q),
      .in_space (in_space),
      .hit      (hit)
   );

   assign reg_sel = (rd_en || wr_en) ? hit : '0;
   assign reg_we  = wr_en ? hit : '0;

   sfr_reg_bank #(.NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .we       (reg_we),
      .bit_mode (bit_mode),
      .bit_idx  (bit_idx),
      .bit_val  (bit_val),
      .wr_data  (wr_data),
      .rd_byte  (bank_rd)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (page_hit)      rd_data = page_q;
         else if (bit_mode) rd_data[0] = bank_rd[bit_idx];
         else               rd_data = bank_rd;
      end
   end

endmodule

// File: rtl/sfr_page_decoder_chk.sv
module sfr_page_decoder_chk
   import sfr_dec_pkg::*;
#(
   parameter int unsigned NUM_REG = MAP_REGS,
   parameter int unsigned DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  dir_addr,
   input logic               rd_en,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic               bit_mode,
   input logic [DATA_W-1:0]  rd_data,
   input logic [NUM_REG-1:0] reg_sel,
   input logic [NUM_REG-1:0] reg_we,
   input logic [PAGE_W-1:0]  page_q
);

   a_r1_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en || wr_en) && !dir_addr[ADDR_W-1] |-> (reg_sel == '0) && (rd_data == '0));

   a_r3_page_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !bit_mode && (dir_addr == PAGE_SEL_ADDR) |=> page_q == $past(wr_data));

   a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !bit_mode && (dir_addr == PAGE_SEL_ADDR)) |=> $stable(page_q));

   a_r5_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   a_r7_unpop_page: assert property (@(posedge clk) disable iff (!rst_n)
      (page_q != PAGE_LO) && (page_q != PAGE_HI) |-> reg_sel == '0);

   a_r8_bit_read_width: assert property (@(posedge clk) disable iff (!rst_n)
      bit_mode && rd_en |-> rd_data[DATA_W-1:1] == '0);

   a_r10_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we != '0 |-> wr_en && (reg_we == reg_sel));

   a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);

endmodule

bind sfr_page_decoder sfr_page_decoder_chk #(.NUM_REG(NUM_REG), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .dir_addr (dir_addr),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .bit_mode (bit_mode),
   .rd_data  (rd_data),
   .reg_sel  (reg_sel),
   .reg_we   (reg_we),
   .page_q   (page_q)
);

// File: tb/sfr_page_decoder_bench.sv
module sfr_page_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NR = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    dir_addr = '0;
   logic          rd_en = 1'b0, wr_en = 1'b0, bit_mode = 1'b0, bit_val = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_data;
   logic [NR-1:0] reg_sel, reg_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0]    rd;
      logic [NR-1:0] sel;
      logic [NR-1:0] we;
      string         req;
   } exp_t;
   exp_t sb[$];

   sfr_page_decoder u_sfr_page_decoder (
      .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .bit_mode(bit_mode), .bit_val(bit_val),
      .rd_data(rd_data), .reg_sel(reg_sel), .reg_we(reg_we)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Driver: one access per cycle, launched on the falling edge.
   task automatic acc(input logic [7:0] a, input logic r, input logic w,
                      input logic [7:0] d, input logic bm, input logic bv,
                      input logic [7:0] e_rd, input logic [NR-1:0] e_sel,
                      input string req);
      exp_t it;
      @(negedge clk);
      dir_addr = a; rd_en = r; wr_en = w; wr_data = d; bit_mode = bm; bit_val = bv;
      it.rd = e_rd; it.sel = e_sel; it.we = w ? e_sel : '0; it.req = req;
      sb.push_back(it);
   endtask

   // Monitor: compares a quarter period after each falling edge.
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (rd_data !== it.rd || reg_sel !== it.sel || reg_we !== it.we) begin
               errors++;
               $display("FAIL %s: addr=%h rd=%h sel=%b we=%b expected rd=%h sel=%b we=%b",
                        it.req, dir_addr, rd_data, reg_sel, reg_we, it.rd, it.sel, it.we);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset state (R2)
      acc(8'hBF, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R2 reset page");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00001, "R10 reset reg");
      // Byte writes on page 0x00 (R10, R4, R5)
      acc(8'h80, 0, 1, 8'hA5, 0, 0, 8'h00, 5'b00001, "R10 write 80");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'hA5, 5'b00001, "R4 read 80 p0");
      acc(8'h88, 0, 1, 8'h11, 0, 0, 8'h00, 5'b00010, "R5 write 88 p0");
      acc(8'h88, 1, 0, 8'h00, 0, 0, 8'h11, 5'b00010, "R5 read 88 p0");
      acc(8'h9A, 0, 1, 8'h22, 0, 0, 8'h00, 5'b01000, "R5 write 9A p0");
      // Reserved addresses (R6)
      acc(8'hC3, 0, 1, 8'h33, 0, 0, 8'h00, 5'b00000, "R6 write C3 on p0");
      acc(8'hC3, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R6 read C3 on p0");
      acc(8'h90, 0, 1, 8'hFF, 0, 0, 8'h00, 5'b00000, "R6 write 90");
      acc(8'h90, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R6 read 90");
      // Low addresses (R1)
      acc(8'h00, 0, 1, 8'h77, 0, 0, 8'h00, 5'b00000, "R1 write 00");
      acc(8'h3F, 0, 1, 8'h5A, 0, 0, 8'h00, 5'b00000, "R1 write 3F");
      acc(8'h00, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R1 read 00");
      acc(8'h05, 0, 1, 8'h00, 1, 1, 8'h00, 5'b00000, "R1 bit write 05");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'hA5, 5'b00001, "R1 80 untouched");
      // Page switch with same-cycle read (R3)
      acc(8'hBF, 1, 1, 8'h0F, 0, 0, 8'h00, 5'b00000, "R3 same-cycle old page");
      acc(8'h88, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00100, "R3 88 on pF");
      acc(8'hBF, 1, 0, 8'h00, 0, 0, 8'h0F, 5'b00000, "R2 read page F");
      acc(8'h88, 0, 1, 8'h44, 0, 0, 8'h00, 5'b00100, "R5 write 88 pF");
      acc(8'h88, 1, 0, 8'h00, 0, 0, 8'h44, 5'b00100, "R5 read 88 pF");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'hA5, 5'b00001, "R4 read 80 pF");
      acc(8'h9A, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R5 9A absent pF");
      acc(8'hC3, 0, 1, 8'h55, 0, 0, 8'h00, 5'b10000, "R5 write C3 pF");
      acc(8'hC3, 1, 0, 8'h00, 0, 0, 8'h55, 5'b10000, "R5 read C3 pF");
      // Unpopulated page (R7)
      acc(8'hBF, 0, 1, 8'h05, 0, 0, 8'h00, 5'b00000, "R2 write page 05");
      acc(8'hBF, 1, 0, 8'h00, 0, 0, 8'h05, 5'b00000, "R2 read page 05");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R7 read 80 p05");
      acc(8'h80, 0, 1, 8'hEE, 0, 0, 8'h00, 5'b00000, "R7 write 80 p05");
      acc(8'hBF, 0, 1, 8'h00, 0, 0, 8'h00, 5'b00000, "R2 back to p0");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'hA5, 5'b00001, "R7 80 unchanged");
      acc(8'h88, 1, 0, 8'h00, 0, 0, 8'h11, 5'b00010, "R5 88 p0 kept");
      acc(8'h9A, 1, 0, 8'h00, 0, 0, 8'h22, 5'b01000, "R5 read 9A p0");
      // Bit access (R8)
      acc(8'h82, 0, 1, 8'h00, 1, 0, 8'h00, 5'b00001, "R8 bit clear 80.2");
      acc(8'h80, 1, 0, 8'h00, 0, 0, 8'hA1, 5'b00001, "R8 byte after bit");
      acc(8'h87, 1, 0, 8'h00, 1, 0, 8'h01, 5'b00001, "R8 bit read 80.7");
      acc(8'h86, 1, 0, 8'h00, 1, 0, 8'h00, 5'b00001, "R8 bit read 80.6");
      acc(8'h8E, 0, 1, 8'hFF, 1, 1, 8'h00, 5'b00010, "R8 bit set 88.6");
      acc(8'h88, 1, 0, 8'h00, 0, 0, 8'h51, 5'b00010, "R8 read 88");
      // Bit access to non-bit-addressable targets (R9)
      acc(8'hBA, 0, 1, 8'hFF, 1, 1, 8'h00, 5'b00000, "R9 bit write BA");
      acc(8'hBF, 1, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R9 page unchanged");
      acc(8'h9A, 0, 1, 8'h00, 1, 1, 8'h00, 5'b00000, "R9 bit write 9A");
      acc(8'h9A, 1, 0, 8'h00, 0, 0, 8'h22, 5'b01000, "R9 9A unchanged");
      // Idle read strobe (R11)
      acc(8'h80, 0, 0, 8'h00, 0, 0, 8'h00, 5'b00000, "R11 no strobe");
      @(negedge clk);
      rd_en = 0; wr_en = 0; bit_mode = 0;
      #(CLK_PERIOD/2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule